// File: doc/BRIEF.md
# Banked UART Host Register Interface

This block is the register file that a host processor sees when it talks to a 16750-class serial port. It decodes a byte-wide bus that has a five-bit offset, a read strobe and a write strobe. The value held in the line-control register decides which register an offset reaches. Bit 7 of that register switches offsets 0 and 1 over to the baud divisor. One special value, 0xBF, also maps an enhanced-feature register at offset 2. A bit in that register controls whether software may change the sleep-enable bit of the interrupt enable register.

The block does not contain the data path. The receive FIFO, the transmit FIFO, the serializer and the baud generator are outside it. They hand in their flags as inputs: the receive-FIFO head byte, the empty and full flags, error pulses and modem events. From these the block builds the interrupt identification and line status views. It also drives the interrupt line. Its outputs are the configuration the data path needs:
- the frame format
- the 16-bit divisor
- the FIFO enable and the FIFO reset pulses
- the mode selection
- the sleep enable

A read of offset 0 pops the receive FIFO through `rx_pop`. A write to offset 0 pushes into the transmit FIFO through `tx_wr`.

Top module: `uart_regbank`

## Requirements
- R1: When line-control bit 7 is 0:
  - A read at offset 0 returns `rx_head` on `rdata` in the same cycle. It raises `rx_pop` in that cycle, but only if `rx_empty` is 0.
  - A write at offset 0 raises `tx_wr` in the same cycle, with `tx_data` equal to `wdata`.
  - `rdata` is 0 whenever `rd_en` is low.
- R2: When line-control bit 7 is 1:
  - Offset 0 reads and writes the divisor low byte, and offset 1 the high byte. `divisor` shows a write from the next cycle on.
  - `tx_wr` and `rx_pop` stay low.
- R3: When the line-control register equals 0xBF, offset 2 reads and writes the enhanced register. For any other line-control value, a read at offset 2 returns the interrupt identification and a write goes to FIFO control.
- R4: A write at offset 1 (line-control bit 7 clear) updates the sleep enable, interrupt-enable bit 4, only while enhanced-register bit 4 is 1. Otherwise `sleep_en` keeps its value.
- R5: Interrupt enable bits are:
  - bit 0: receive data available
  - bit 1: transmit holding empty
  - bit 2: receiver line status
  - bit 3: modem status
  Bits 7:5 always read 0.
- R6: Identification reads back as follows:
  - Bits 3:0 are 0x1 when no enabled cause is pending.
  - Otherwise bits 3:0 hold the highest pending enabled cause, in priority order: line status 0x6, receive data 0x4, transmit empty 0x2, modem status 0x0.
  - Bits 7:6 both equal the FIFO-enable bit, and bits 5:4 are 0.
- R7: A FIFO-control write stores `wdata[0]` into `fifo_en`. If `wdata[1]` is set, it pulses `rx_fifo_rst` for exactly the next cycle; `wdata[2]` does the same for `tx_fifo_rst`.
- R8: Line status at offset 5 has these bits:
  - bit 0: not `rx_empty`
  - bits 1–4: sticky overrun, parity, framing and break, set by the matching input pulses
  - bit 5: `tx_fifo_empty`
  - bit 6: `tx_fifo_empty` and `tx_shift_empty` both high
  Reading offset 5 clears bits 1–4 from the next cycle on. An error pulse in the same cycle as that read wins over the clear.
- R9: A transmit-empty pending flag sets when `tx_fifo_empty` rises. It clears on a transmit-holding write, or on an identification read that reports code 0x2. A new rise in the same cycle wins over the clear.
- R10: `irq` is high in exactly those cycles in which at least one enabled cause is pending.
- R11: Line-control fields drive the outputs:
  - bits 1:0 → `word_len`
  - bit 2 → `two_stop`
  - bit 3 → `parity_en`
  - bit 4 → `even_parity`
  - bit 6 → `break_ctl`
- R12: The other registers behave as follows:
  - Offset 8 is a read/write mode register that drives `mode_sel`.
  - Offset 0x11 reads `tx_fifo_full` in bit 0.
  - Offset 6 reads `modem_stat`. Reading it clears the modem pending flag, which `modem_change` sets; a `modem_change` pulse in the same cycle wins.
  - Any other offset reads 0.
- R13: After reset:
  - line control, interrupt enable, enhanced register, divisor and FIFO enable are 0
  - the mode register is 0x07
  - no cause is pending

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, same cycle as rd_en |
| tx_wr | output | 1 | Push into transmit FIFO |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop receive FIFO |
| rx_head | input | 8 | Byte at the receive FIFO head |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_break | input | 1 | Break detected pulse |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| modem_change | input | 1 | Modem line change pulse |
| modem_stat | input | 8 | Modem status byte |
| word_len | output | 2 | Data bits minus 5 |
| two_stop | output | 1 | Extra stop bits |
| parity_en | output | 1 | Parity enable |
| even_parity | output | 1 | Even parity select |
| break_ctl | output | 1 | Force break |
| divisor | output | 16 | Baud divisor |
| fifo_en | output | 1 | FIFO enable |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |
| sleep_en | output | 1 | Sleep enable |
| mode_sel | output | 8 | Mode register |
| irq | output | 1 | Interrupt request |

## Verification
These results appear in the same cycle as the strobe:
- `rdata`, `tx_wr`, `tx_data`, `rx_pop` and `irq`
- the identification code, since it is computed from the current state and inputs

A register write or a clearing read has its effect from the cycle after its edge. The FIFO reset pulses are high only in the cycle right after the write. The bench drives each cycle's inputs just after the falling edge, then compares every output against its model a moment later, before the rising edge. Only after that compare does it advance the model state, which mirrors the timing of the design's registers.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam logic [7:0] OFF_DATA = 8'h00;
    localparam logic [7:0] OFF_IEN  = 8'h01;
    localparam logic [7:0] OFF_IDF  = 8'h02;
    localparam logic [7:0] OFF_LCTL = 8'h03;
    localparam logic [7:0] OFF_LSTA = 8'h05;
    localparam logic [7:0] OFF_MSTA = 8'h06;
    localparam logic [7:0] OFF_MODE = 8'h08;
    localparam logic [7:0] OFF_SSTA = 8'h11;

    // interrupt identification low nibble
    typedef enum logic [3:0] {
        CAUSE_NONE = 4'h1,
        CAUSE_LINE = 4'h6,
        CAUSE_RXD  = 4'h4,
        CAUSE_TXE  = 4'h2,
        CAUSE_MDM  = 4'h0
    } cause_e;

    typedef struct packed {
        logic rhr_thr;
        logic div_lo;
        logic ien;
        logic div_hi;
        logic enh;
        logic iir_fcr;
        logic lctl;
        logic lsta;
        logic msta;
        logic mode;
        logic ssta;
    } sel_t;

    typedef struct packed {
        logic [7:0] lctl;
        logic [7:0] ien;
        logic [7:0] enh;
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic [7:0] mode;
        logic       fen;
        logic       rx_rst;
        logic       tx_rst;
        logic [3:0] err;      // 0 overrun, 1 parity, 2 framing, 3 break
        logic       txe_pend;
        logic       mdm_pend;
        logic       txe_prev;
    } regs_t;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
#(
    parameter int         ADDR_W   = 5,
    parameter logic [7:0] BANK_KEY = 8'hBF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        lctl,
    output sel_t              sel
);
    logic divisor_bank;
    logic enh_bank;

    always_comb begin
        divisor_bank = lctl[7];
        enh_bank     = (lctl == BANK_KEY);
        sel          = '0;
        sel.rhr_thr  = (addr == ADDR_W'(OFF_DATA)) && !divisor_bank;
        sel.div_lo   = (addr == ADDR_W'(OFF_DATA)) &&  divisor_bank;
        sel.ien      = (addr == ADDR_W'(OFF_IEN))  && !divisor_bank;
        sel.div_hi   = (addr == ADDR_W'(OFF_IEN))  &&  divisor_bank;
        sel.enh      = (addr == ADDR_W'(OFF_IDF))  &&  enh_bank;
        sel.iir_fcr  = (addr == ADDR_W'(OFF_IDF))  && !enh_bank;
        sel.lctl     = (addr == ADDR_W'(OFF_LCTL));
        sel.lsta     = (addr == ADDR_W'(OFF_LSTA));
        sel.msta     = (addr == ADDR_W'(OFF_MSTA));
        sel.mode     = (addr == ADDR_W'(OFF_MODE));
        sel.ssta     = (addr == ADDR_W'(OFF_SSTA));
    end
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       err_any,
    input  logic       rx_avail,
    input  logic       txe_pend,
    input  logic       mdm_pend,
    input  logic       fen,
    output cause_e     cause,
    output logic [7:0] iir,
    output logic       irq
);
    always_comb begin
        if (ien[2] && err_any)       cause = CAUSE_LINE;
        else if (ien[0] && rx_avail) cause = CAUSE_RXD;
        else if (ien[1] && txe_pend) cause = CAUSE_TXE;
        else if (ien[3] && mdm_pend) cause = CAUSE_MDM;
        else                         cause = CAUSE_NONE;
        iir = {fen, fen, 2'b00, cause};
        irq = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int         ADDR_W    = 5,
    parameter logic [7:0] BANK_KEY  = 8'hBF,
    parameter logic [7:0] MODE_INIT = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              tx_wr,
    output logic [7:0]        tx_data,
    output logic              rx_pop,
    input  logic [7:0]        rx_head,
    input  logic              rx_empty,
    input  logic              rx_overrun,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic              tx_fifo_full,
    input  logic              modem_change,
    input  logic [7:0]        modem_stat,
    output logic [1:0]        word_len,
    output logic              two_stop,
    output logic              parity_en,
    output logic              even_parity,
    output logic              break_ctl,
    output logic [15:0]       divisor,
    output logic              fifo_en,
    output logic              rx_fifo_rst,
    output logic              tx_fifo_rst,
    output logic              sleep_en,
    output logic [7:0]        mode_sel,
    output logic              irq
);
    localparam regs_t REGS_RESET = '{
        lctl: 8'h00, ien: 8'h00, enh: 8'h00, div_lo: 8'h00, div_hi: 8'h00,
        mode: MODE_INIT, fen: 1'b0, rx_rst: 1'b0, tx_rst: 1'b0, err: 4'h0,
        txe_pend: 1'b0, mdm_pend: 1'b0, txe_prev: 1'b1
    };

    regs_t      r_q, r_d;
    sel_t       sel;
    cause_e     cause;
    logic [7:0] iir_w;
    logic [7:0] lsta_w;
    logic       irq_w;

    uart_rb_decode #(.ADDR_W(ADDR_W), .BANK_KEY(BANK_KEY)) u_decode (
        .addr (addr),
        .lctl (r_q.lctl),
        .sel  (sel)
    );

    uart_rb_irq u_irq (
        .ien      (r_q.ien[3:0]),
        .err_any  (|r_q.err),
        .rx_avail (!rx_empty),
        .txe_pend (r_q.txe_pend),
        .mdm_pend (r_q.mdm_pend),
        .fen      (r_q.fen),
        .cause    (cause),
        .iir      (iir_w),
        .irq      (irq_w)
    );

    // line status view
    always_comb begin
        lsta_w = {1'b0, tx_fifo_empty && tx_shift_empty, tx_fifo_empty,
                  r_q.err, !rx_empty};
    end

    // read mux
    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            unique case (1'b1)
                sel.rhr_thr: rdata = rx_head;
                sel.div_lo:  rdata = r_q.div_lo;
                sel.ien:     rdata = r_q.ien;
                sel.div_hi:  rdata = r_q.div_hi;
                sel.enh:     rdata = r_q.enh;
                sel.iir_fcr: rdata = iir_w;
                sel.lctl:    rdata = r_q.lctl;
                sel.lsta:    rdata = lsta_w;
                sel.msta:    rdata = modem_stat;
                sel.mode:    rdata = r_q.mode;
                sel.ssta:    rdata = {7'b0, tx_fifo_full};
                default:     rdata = 8'h00;
            endcase
        end
    end

    // next state
    always_comb begin
        r_d        = r_q;
        r_d.rx_rst = 1'b0;
        r_d.tx_rst = 1'b0;
        if (wr_en) begin
            if (sel.div_lo) r_d.div_lo = wdata;
            if (sel.div_hi) r_d.div_hi = wdata;
            if (sel.ien)
                r_d.ien = {3'b000, r_q.enh[4] ? wdata[4] : r_q.ien[4], wdata[3:0]};
            if (sel.enh)  r_d.enh  = wdata;
            if (sel.lctl) r_d.lctl = wdata;
            if (sel.mode) r_d.mode = wdata;
            if (sel.iir_fcr) begin
                r_d.fen    = wdata[0];
                r_d.rx_rst = wdata[1];
                r_d.tx_rst = wdata[2];
            end
        end
        if (rd_en && sel.lsta) r_d.err = 4'h0;
        r_d.err = r_d.err | {rx_break, rx_frame_err, rx_parity_err, rx_overrun};
        if ((wr_en && sel.rhr_thr) || (rd_en && sel.iir_fcr && cause == CAUSE_TXE))
            r_d.txe_pend = 1'b0;
        if (tx_fifo_empty && !r_q.txe_prev)
            r_d.txe_pend = 1'b1;
        if (rd_en && sel.msta) r_d.mdm_pend = 1'b0;
        if (modem_change)      r_d.mdm_pend = 1'b1;
        r_d.txe_prev = tx_fifo_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign tx_wr       = wr_en && sel.rhr_thr;
    assign tx_data     = wdata;
    assign rx_pop      = rd_en && sel.rhr_thr && !rx_empty;
    assign word_len    = r_q.lctl[1:0];
    assign two_stop    = r_q.lctl[2];
    assign parity_en   = r_q.lctl[3];
    assign even_parity = r_q.lctl[4];
    assign break_ctl   = r_q.lctl[6];
    assign divisor     = {r_q.div_hi, r_q.div_lo};
    assign fifo_en     = r_q.fen;
    assign rx_fifo_rst = r_q.rx_rst;
    assign tx_fifo_rst = r_q.tx_rst;
    assign sleep_en    = r_q.ien[4];
    assign mode_sel    = r_q.mode;
    assign irq         = irq_w;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int         ADDR_W   = 5,
    parameter logic [7:0] BANK_KEY = 8'hBF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        wdata,
    input logic              rx_empty,
    input logic              tx_wr,
    input logic              rx_pop,
    input logic [7:0]        lctl,
    input logic [7:0]        enh,
    input logic [7:0]        iir,
    input logic [7:0]        lsta,
    input logic [3:0]        err_in,
    input logic [15:0]       divisor,
    input logic              rx_fifo_rst,
    input logic              sleep_en,
    input logic              irq
);
    AST_POP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rd_en && !rx_empty && addr == ADDR_W'(0))); // R1
    AST_DIV_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lctl[7] |-> (!tx_wr && !rx_pop)); // R2
    AST_DIV_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && lctl[7]) |=> (divisor[7:0] == $past(wdata))); // R2
    AST_SLEEP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1) && !lctl[7] && !enh[4]) |=> $stable(sleep_en)); // R4
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != iir[0])); // R6
    AST_RX_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_rst |-> $past(wr_en && addr == ADDR_W'(2) && lctl != BANK_KEY && wdata[1])); // R7
    AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(5) && err_in == 4'h0) |=> (lsta[4:1] == 4'h0)); // R8
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .BANK_KEY(BANK_KEY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .rx_empty    (rx_empty),
    .tx_wr       (tx_wr),
    .rx_pop      (rx_pop),
    .lctl        (r_q.lctl),
    .enh         (r_q.enh),
    .iir         (iir_w),
    .lsta        (lsta_w),
    .err_in      ({rx_break, rx_frame_err, rx_parity_err, rx_overrun}),
    .divisor     (divisor),
    .rx_fifo_rst (rx_fifo_rst),
    .sleep_en    (sleep_en),
    .irq         (irq)
);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic [4:0] addr;
    logic       rd_en, wr_en;
    logic [7:0] wdata, rdata, tx_data, rx_head, modem_stat, mode_sel;
    logic       tx_wr, rx_pop, rx_empty, rx_overrun, rx_parity_err, rx_frame_err, rx_break;
    logic       tx_fifo_empty, tx_shift_empty, tx_fifo_full, modem_change;
    logic [1:0] word_len;
    logic       two_stop, parity_en, even_parity, break_ctl, fifo_en;
    logic       rx_fifo_rst, tx_fifo_rst, sleep_en, irq;
    logic [15:0] divisor;

    uart_regbank uut (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    string irq_tag = "R10";

    // behavioural reference state
    int m_lctl, m_ien, m_enh, m_dlo, m_dhi, m_mode, m_fen, m_rxr, m_txr;
    int m_err[4];
    int m_txp, m_msp, m_prev;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int cause();
        int anyerr = m_err[0] | m_err[1] | m_err[2] | m_err[3];
        if ((m_ien & 4) != 0 && anyerr != 0) return 6;
        if ((m_ien & 1) != 0 && !rx_empty) return 4;
        if ((m_ien & 2) != 0 && m_txp != 0) return 2;
        if ((m_ien & 8) != 0 && m_msp != 0) return 0;
        return 1;
    endfunction

    function automatic int exp_read(output string tag);
        int a = addr;
        bit key = (m_lctl == 8'hBF);
        bit dl = (m_lctl >= 128);
        tag = "R12";
        if (!rd_en) begin tag = "R1"; return 0; end
        if (a == 0) begin tag = dl ? "R2" : "R1"; return dl ? m_dlo : rx_head; end
        if (a == 1) begin tag = dl ? "R2" : "R5"; return dl ? m_dhi : m_ien; end
        if (a == 2) begin
            if (key) begin tag = "R3"; return m_enh; end
            tag = "R6"; return (m_fen ? 8'hC0 : 0) | cause();
        end
        if (a == 3) begin tag = "R11"; return m_lctl; end
        if (a == 5) begin
            tag = "R8";
            return (!rx_empty) | (m_err[0] << 1) | (m_err[1] << 2) | (m_err[2] << 3)
                 | (m_err[3] << 4) | (tx_fifo_empty << 5) | ((tx_fifo_empty & tx_shift_empty) << 6);
        end
        if (a == 6) return modem_stat;
        if (a == 8) return m_mode;
        if (a == 17) return tx_fifo_full;
        return 0;
    endfunction

    task automatic compare_now();
        string t;
        int e;
        bit dl = (m_lctl >= 128);
        e = exp_read(t);
        chk(t, rdata, e);
        chk("R1", tx_wr, (wr_en && addr == 0 && !dl));
        if (wr_en && addr == 0 && !dl) chk("R1", tx_data, wdata);
        chk("R1", rx_pop, (rd_en && addr == 0 && !dl && !rx_empty));
        chk(irq_tag, irq, cause() != 1);
        chk("R11", {word_len, two_stop, parity_en, even_parity, break_ctl},
            {m_lctl[1:0], m_lctl[2], m_lctl[3], m_lctl[4], m_lctl[6]});
        chk("R2", divisor, m_dhi * 256 + m_dlo);
        chk("R7", {fifo_en, rx_fifo_rst, tx_fifo_rst}, {m_fen[0], m_rxr[0], m_txr[0]});
        chk("R4", sleep_en, (m_ien >> 4) & 1);
        chk("R12", mode_sel, m_mode);
    endtask

    task automatic model_edge();
        int a = addr;
        int w = wdata;
        bit key = (m_lctl == 8'hBF);
        bit dl = (m_lctl >= 128);
        int c = cause();
        m_rxr = 0; m_txr = 0;
        if (wr_en) begin
            if (a == 0 && dl) m_dlo = w;
            if (a == 1 && dl) m_dhi = w;
            if (a == 1 && !dl) m_ien = (w & 15) | (((m_enh & 16) != 0) ? (w & 16) : (m_ien & 16));
            if (a == 2 && key) m_enh = w;
            if (a == 2 && !key) begin m_fen = w & 1; m_rxr = (w >> 1) & 1; m_txr = (w >> 2) & 1; end
            if (a == 3) m_lctl = w;
            if (a == 8) m_mode = w;
        end
        if (rd_en && a == 5) foreach (m_err[i]) m_err[i] = 0;
        if (rx_overrun)    m_err[0] = 1;
        if (rx_parity_err) m_err[1] = 1;
        if (rx_frame_err)  m_err[2] = 1;
        if (rx_break)      m_err[3] = 1;
        if ((wr_en && a == 0 && !dl) || (rd_en && a == 2 && !key && c == 2)) m_txp = 0;
        if (tx_fifo_empty && !m_prev) m_txp = 1;
        if (rd_en && a == 6) m_msp = 0;
        if (modem_change) m_msp = 1;
        m_prev = tx_fifo_empty;
    endtask

    task automatic cyc();
        #1;
        compare_now();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        {rx_overrun, rx_parity_err, rx_frame_err, rx_break, modem_change} = '0;
    endtask

    task automatic wr(int a, int d);
        addr = 5'(a); wdata = 8'(d); wr_en = 1; cyc();
    endtask

    task automatic rd(int a);
        addr = 5'(a); rd_en = 1; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; addr = 0; rd_en = 0; wr_en = 0; wdata = 0; rx_head = 8'h5A; rx_empty = 1;
        {rx_overrun, rx_parity_err, rx_frame_err, rx_break, modem_change} = '0;
        tx_fifo_empty = 1; tx_shift_empty = 1; tx_fifo_full = 0; modem_stat = 8'h3C;
        m_lctl = 0; m_ien = 0; m_enh = 0; m_dlo = 0; m_dhi = 0; m_mode = 7; m_fen = 0;
        m_rxr = 0; m_txr = 0; m_txp = 0; m_msp = 0; m_prev = 1;
        foreach (m_err[i]) m_err[i] = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", {divisor, mode_sel, fifo_en, sleep_en, irq}, {16'h0, 8'h07, 3'b000});
        rst_n = 1;
        @(negedge clk);
        rd(2); rd(3); rd(8);
        wr(3, 8'h1B);               // R11 frame format
        wr(1, 8'h1F); rd(1);        // R4 sleep blocked, R5 bits
        wr(3, 8'hBF); wr(2, 8'h10); rd(2); // R3 enhanced bank
        wr(0, 8'h07); wr(1, 8'h01); rd(0); rd(1); // R2 divisor
        wr(3, 8'h43);
        wr(2, 8'h07); cyc(); rd(2); // R7 pulses
        wr(1, 8'h1F); rd(1);        // R4 sleep now writable
        rx_empty = 0; rd(0); rd(2); // R1 pop, R6 rx cause
        rx_parity_err = 1; cyc(); rd(2);
        rx_break = 1; rd(5);        // R8 error wins over clear
        rd(5); rd(5);
        rx_empty = 1;
        irq_tag = "R9";
        tx_fifo_empty = 0; cyc(); tx_fifo_empty = 1; cyc(); rd(2); rd(2);
        tx_fifo_empty = 0; cyc(); tx_fifo_empty = 1; cyc(); wr(0, 8'hA5); cyc();
        irq_tag = "R10";
        modem_change = 1; cyc(); rd(2); rd(6); rd(2);
        wr(8, 0); rd(8); tx_fifo_full = 1; rd(17); rd(9);
        wr(3, 8'h80); rd(0);        // divisor bank, no pop
        for (int n = 0; n < 4000; n++) begin
            int sel = $urandom % 10;
            int offs[10] = '{0, 1, 2, 3, 5, 6, 8, 17, 4, 7};
            rx_empty = ($urandom % 3) == 0;
            rx_head = 8'($urandom);
            tx_fifo_empty = ($urandom % 4) != 0;
            tx_shift_empty = $urandom % 2;
            tx_fifo_full = ($urandom % 5) == 0;
            modem_stat = 8'($urandom);
            rx_overrun = ($urandom % 16) == 0;
            rx_frame_err = ($urandom % 16) == 0;
            modem_change = ($urandom % 12) == 0;
            addr = 5'(offs[sel]);
            wdata = (offs[sel] == 3 && ($urandom % 3) == 0) ? 8'hBF : 8'($urandom);
            if ($urandom % 2) rd_en = 1; else wr_en = 1;
            cyc();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule